// File: doc/BRIEF.md
# Interleaved Output Combiner with Offset Cancellation

This block takes the signed results of four interleaved converter channels and merges them into a single full-rate output stream. A phase counter selects the channels in a fixed rotation, so each channel contributes one sample in every four output cycles. A `sync` pulse realigns the rotation: the sample present in that cycle belongs to channel 0.

A reference comparator supplies a per-sample window flag that marks input samples lying close to zero. For each channel the block counts that channel's samples in blocks of 2^BLK_LOG2. Within a block it adds up only the samples whose flag is set, and it keeps a count of them. When a block closes, the channel's offset register is loaded with the mean of those flagged samples. From then on, that offset is subtracted from every output of the channel. The subtraction is clamped to the signed output range. The output is registered, which gives one cycle of latency. Gain differences between channels are left uncorrected.

Top module: `ilv_offset_combiner`

## Requirements
- R1: With `sync` low, the channel served advances 0, 1, 2, 3, 0, ... one step per cycle. The first sample after reset is channel 0. The `out_chan` output reports the channel of the result on `out_code`, and that result appears one cycle after its sample is presented.
- R2: Channel codes are 10-bit two's-complement values. Channel k occupies bits [10k+9:10k] of `chan_codes`. After reset, `out_code` is 0, `out_chan` is 0 and every offset is 0. While the offsets are 0, `out_code` is the sign-extended code of the selected channel.
- R3: When `sync` is high, the sample in that cycle is taken from channel 0. The next cycle serves channel 1.
- R4: A channel's offset is the mean of the samples that had `win_flag` high, taken over one block of 16 samples of that channel. Samples with the flag low do not affect the offset. The new offset applies from the channel's first sample after the last sample of the block.
- R5: Each result is its own channel's code minus that same channel's offset. No other channel's offset is involved.
- R6: If a block closes with no flagged samples, the channel keeps its previous offset.
- R7: The mean is truncated toward zero. For example, flagged values summing to -40 over 16 samples give -2.
- R8: The difference is clamped to the signed limits of the 11-bit output. At the default widths, the extremes -1023 and +1023 come out exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Forces the current sample to channel 0 |
| chan_codes | input | 40 | Four packed signed channel codes, channel 0 in the low bits |
| win_flag | input | 1 | Marks the current sample as near zero |
| out_code | output | 11 | Corrected signed output sample |
| out_chan | output | 2 | Channel index of `out_code` |

## Verification
Every output is due exactly one clock after its sample, so the bench drives each sample on a falling edge and compares on the next falling edge, after the single output register has loaded. A new offset takes effect on the sample after a block's last sample, and that last sample still uses the old offset. The bench model therefore computes each expected value before it applies the block-end update, and every literal check is placed in the rotation after the block closes.

// File: rtl/ilvc_pkg.sv
// Package: shared default sizes for the interleaved combiner.
// Assumes: nothing; constants only.
package ilvc_pkg;
    localparam int DEF_NUM_CH   = 4;
    localparam int DEF_CODE_W   = 10;
    localparam int DEF_OUT_W    = 11;
    localparam int DEF_BLK_LOG2 = 4;
endpackage

// File: rtl/ilvc_phase.sv
// Module: round-robin phase generator.
// Produces the channel index of the sample present this cycle.
// Assumes: sync forces index 0 for the current cycle.
module ilvc_phase #(
    parameter int NUM_CH = 4,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync,
    output logic [CH_W-1:0] cur
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] phase_q;

    // Current index: forced to zero by sync, else the stored phase.
    always_comb cur = sync ? '0 : phase_q;

    // Advance the phase with wrap at the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else
            phase_q <= (cur == LAST) ? '0 : cur + 1'b1;
    end
endmodule

// File: rtl/ilvc_mean_div.sv
// Module: signed sum divided by an unsigned count, truncated toward zero.
// Restoring division on the magnitude, sign restored afterwards.
// Assumes: cnt is nonzero whenever the result is used.
module ilvc_mean_div #(
    parameter int SUM_W = 14,
    parameter int CNT_W = 5
) (
    input  logic signed [SUM_W-1:0] sum,
    input  logic        [CNT_W-1:0] cnt,
    output logic signed [SUM_W-1:0] quo
);
    logic [SUM_W-1:0] mag;
    logic [SUM_W-1:0] q;
    logic [CNT_W:0]   rem;

    // Magnitude of the dividend.
    always_comb mag = sum[SUM_W-1] ? (~sum + 1'b1) : sum;

    // Bit-serial restoring division, unrolled.
    always_comb begin
        rem = '0;
        q   = '0;
        for (int i = SUM_W - 1; i >= 0; i--) begin
            rem = {rem[CNT_W-1:0], mag[i]};
            if (rem >= {1'b0, cnt}) begin
                rem  = rem - {1'b0, cnt};
                q[i] = 1'b1;
            end
        end
    end

    // Restore sign so the result truncates toward zero.
    always_comb quo = sum[SUM_W-1] ? -$signed(q) : $signed(q);
endmodule

// File: rtl/ilvc_chan_acc.sv
// Module: per-channel flagged-sample accumulator and offset register.
// Counts this channel's samples in blocks of 2^BLK_LOG2. It sums only
// the flagged samples and loads the offset with their mean when a block
// closes. A block with no flagged samples keeps the previous offset.
// Assumes: sel is high exactly on cycles carrying this channel's sample.
module ilvc_chan_acc #(
    parameter int CODE_W   = 10,
    parameter int BLK_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic signed [CODE_W-1:0] code,
    input  logic                     flag,
    output logic signed [CODE_W-1:0] offset
);
    localparam int SUM_W = CODE_W + BLK_LOG2 + 1;
    localparam int CNT_W = BLK_LOG2 + 1;
    localparam logic signed [SUM_W-1:0] QMAX = SUM_W'((1 << (CODE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] QMIN = -QMAX - 1;

    logic        [BLK_LOG2-1:0] smp_cnt;
    logic signed [SUM_W-1:0]    fsum;
    logic        [CNT_W-1:0]    fcnt;
    logic signed [SUM_W-1:0]    add_sum;
    logic        [CNT_W-1:0]    add_cnt;
    logic signed [SUM_W-1:0]    quo;
    logic signed [CODE_W-1:0]   mean;
    logic                       last;

    // Running totals including the present sample.
    always_comb begin
        add_sum = fsum + (flag ? SUM_W'(code) : '0);
        add_cnt = fcnt + CNT_W'(flag);
        last    = &smp_cnt;
    end

    ilvc_mean_div #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_div (
        .sum (add_sum),
        .cnt (add_cnt),
        .quo (quo)
    );

    // Bound the quotient to the code range (guards the register width).
    always_comb begin
        if (quo > QMAX)      mean = QMAX[CODE_W-1:0];
        else if (quo < QMIN) mean = QMIN[CODE_W-1:0];
        else                 mean = quo[CODE_W-1:0];
    end

    // Accumulate flagged samples and update the offset at the block end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            fsum    <= '0;
            fcnt    <= '0;
            offset  <= '0;
        end else if (sel) begin
            smp_cnt <= smp_cnt + 1'b1;
            if (last) begin
                fsum <= '0;
                fcnt <= '0;
                if (add_cnt != '0)
                    offset <= mean;
            end else begin
                fsum <= add_sum;
                fcnt <= add_cnt;
            end
        end
    end
endmodule

// File: rtl/ilvc_sat_sub.sv
// Module: signed code minus offset, clamped to the signed output width.
// Assumes: code and offset share one width.
module ilvc_sat_sub #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 11
) (
    input  logic signed [IN_W-1:0]  code,
    input  logic signed [IN_W-1:0]  off,
    output logic signed [OUT_W-1:0] res
);
    localparam int D_W = IN_W + 1;

    logic signed [D_W-1:0] diff;

    // Exact difference at one extra bit.
    always_comb diff = D_W'(code) - D_W'(off);

    generate
        if (OUT_W >= D_W) begin : g_wide
            // Output holds every difference: sign-extend only.
            always_comb res = OUT_W'(diff);
        end else begin : g_clamp
            localparam logic signed [D_W-1:0] HI = D_W'((1 << (OUT_W - 1)) - 1);
            localparam logic signed [D_W-1:0] LO = -HI - 1;
            // Clamp to the signed output limits.
            always_comb begin
                if (diff > HI)      res = HI[OUT_W-1:0];
                else if (diff < LO) res = LO[OUT_W-1:0];
                else                res = diff[OUT_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/ilv_offset_combiner.sv
// Module: top of the interleaved combiner with per-channel offset removal.
// Selects one channel per cycle in rotation. Keeps a flag-qualified mean
// per channel, subtracts it from that channel's samples and registers
// the result together with its channel index.
// Assumes: one sample per cycle; chan_codes packs channel k at k*CODE_W.
module ilv_offset_combiner
    import ilvc_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int OUT_W    = DEF_OUT_W,
    parameter int BLK_LOG2 = DEF_BLK_LOG2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sync,
    input  logic [NUM_CH*CODE_W-1:0]   chan_codes,
    input  logic                       win_flag,
    output logic signed [OUT_W-1:0]    out_code,
    output logic [$clog2(NUM_CH)-1:0]  out_chan
);
    localparam int CH_W = $clog2(NUM_CH);

    logic signed [CODE_W-1:0] codes [NUM_CH];
    logic signed [CODE_W-1:0] offs  [NUM_CH];
    logic [NUM_CH*CODE_W-1:0] offs_flat;
    logic [CH_W-1:0]          cur;
    logic signed [CODE_W-1:0] code_sel;
    logic signed [CODE_W-1:0] off_sel;
    logic signed [OUT_W-1:0]  corr;

    ilvc_phase #(.NUM_CH(NUM_CH)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (sync),
        .cur   (cur)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign codes[g] = chan_codes[g*CODE_W +: CODE_W];
            assign offs_flat[g*CODE_W +: CODE_W] = offs[g];

            ilvc_chan_acc #(.CODE_W(CODE_W), .BLK_LOG2(BLK_LOG2)) u_acc (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel    (cur == CH_W'(g)),
                .code   (codes[g]),
                .flag   (win_flag),
                .offset (offs[g])
            );
        end
    endgenerate

    // Multiplex the current channel's code and offset.
    always_comb begin
        code_sel = codes[cur];
        off_sel  = offs[cur];
    end

    ilvc_sat_sub #(.IN_W(CODE_W), .OUT_W(OUT_W)) u_sub (
        .code (code_sel),
        .off  (off_sel),
        .res  (corr)
    );

    // Output register: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code <= '0;
            out_chan <= '0;
        end else begin
            out_code <= corr;
            out_chan <= cur;
        end
    end
endmodule

// File: rtl/ilvc_chk.sv
// Module: property checker bound to the combiner top.
// Watches the ports and the packed offset state.
module ilvc_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 10,
    parameter int OUT_W  = 11
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             sync,
    input logic [NUM_CH*CODE_W-1:0]         chan_codes,
    input logic                             win_flag,
    input logic signed [OUT_W-1:0]          out_code,
    input logic [$clog2(NUM_CH)-1:0]        out_chan,
    input logic [NUM_CH*CODE_W-1:0]         offs_flat
);
    localparam int CH_W = $clog2(NUM_CH);

    logic pv_q;
    logic seen_q;

    // Marks that at least one edge has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    // Sticky record of any flagged sample since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (win_flag) seen_q <= 1'b1;
    end

    function automatic logic signed [OUT_W-1:0] pick(
        input logic [NUM_CH*CODE_W-1:0] v, input logic [CH_W-1:0] k);
        logic signed [CODE_W-1:0] c;
        c = v[k*CODE_W +: CODE_W];
        return OUT_W'(c);
    endfunction

    function automatic logic [CH_W-1:0] nxt(input logic [CH_W-1:0] k);
        return (k == CH_W'(NUM_CH - 1)) ? '0 : k + 1'b1;
    endfunction

    // R1: channel index steps by one each cycle without sync.
    p_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && !sync) |=> (out_chan == nxt($past(out_chan))));

    // R3: a sync sample is reported as channel 0.
    p_sync_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (out_chan == '0));

    // R2: before any flagged sample the output is the plain selected code.
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q) |=> (out_code == pick($past(chan_codes), out_chan)));

    // R6: offsets stay zero until some sample has been flagged.
    p_offs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q) |-> (offs_flat == '0));
endmodule

bind ilv_offset_combiner ilvc_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync       (sync),
    .chan_codes (chan_codes),
    .win_flag   (win_flag),
    .out_code   (out_code),
    .out_chan   (out_chan),
    .offs_flat  (offs_flat)
);

// File: tb/test_ilv_offset_combiner.sv
// Bench: sweeps codes, flags and sync against an arithmetic model.
module test_ilv_offset_combiner;
    localparam int NCH = 4;
    localparam int BLK = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sync = 1'b0;
    logic [NCH*10-1:0]   chan_codes = '0;
    logic                win_flag = 1'b0;
    logic signed [10:0]  out_code;
    logic [1:0]          out_chan;

    int n_chk = 0;
    int n_bad = 0;

    int m_ph;
    int m_off  [NCH];
    int m_sum  [NCH];
    int m_fcnt [NCH];
    int m_scnt [NCH];

    always #4 clk = ~clk;

    ilv_offset_combiner i_ilv_offset_combiner (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync       (sync),
        .chan_codes (chan_codes),
        .win_flag   (win_flag),
        .out_code   (out_code),
        .out_chan   (out_chan)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp11(input int v);
        if (v > 1023)  return 1023;
        if (v < -1024) return -1024;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sync = 1'b0; win_flag = 1'b0; chan_codes = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(int'(out_code), 0, "R2 reset code");
        chk(int'(out_chan), 0, "R2 reset chan");
        m_ph = 0;
        for (int k = 0; k < NCH; k++) begin
            m_off[k] = 0; m_sum[k] = 0; m_fcnt[k] = 0; m_scnt[k] = 0;
        end
        rst_n = 1'b1;
    endtask

    // One sample: drive at falling edge, compare at the next falling edge.
    task automatic step(input int c0, input int c1, input int c2, input int c3,
                        input bit flg, input bit syn, input string req);
        int c [NCH];
        int cur;
        int exp_v;
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        chan_codes = {10'(c3), 10'(c2), 10'(c1), 10'(c0)};
        win_flag   = flg;
        sync       = syn;
        cur   = syn ? 0 : m_ph;
        exp_v = clamp11(c[cur] - m_off[cur]);
        m_ph  = (cur + 1) % NCH;
        if (flg) begin
            m_sum[cur]  += c[cur];
            m_fcnt[cur] += 1;
        end
        m_scnt[cur] += 1;
        if (m_scnt[cur] == BLK) begin
            if (m_fcnt[cur] != 0) m_off[cur] = m_sum[cur] / m_fcnt[cur];
            m_sum[cur] = 0; m_fcnt[cur] = 0; m_scnt[cur] = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(int'(out_code), exp_v, req);
        chk(int'(out_chan), cur, "R1 channel index");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lf;
        do_reset();

        // R1 R2: rotation with zero offsets, every code value, no flags.
        for (int v = -512; v < 512; v++)
            step(v, -v - 1, v, -v - 1, 1'b0, 1'b0, "R2 passthrough");

        // R4 R5 R7: literal block with per-channel flag patterns.
        do_reset();
        for (int r = 0; r < BLK; r++) begin
            step(5, 0, 0, 0, 1'b1, 1'b0, "R4 block ch0");
            step(0, (r % 2 == 0) ? -3 : -2, 0, 0, 1'b1, 1'b0, "R7 block ch1");
            step(0, 0, (r == 0) ? 7 : 300, 0, (r == 0), 1'b0, "R4 block ch2");
            step(0, 0, 0, 200, 1'b0, 1'b0, "R6 block ch3");
        end
        step(100, 0, 0, 0, 1'b0, 1'b0, "R5 ch0");
        chk(int'(out_code), 95, "R4 ch0 mean 5");
        step(0, 100, 0, 0, 1'b0, 1'b0, "R5 ch1");
        chk(int'(out_code), 102, "R7 ch1 mean -2");
        step(0, 0, 100, 0, 1'b0, 1'b0, "R5 ch2");
        chk(int'(out_code), 93, "R4 ch2 unflagged ignored");
        step(0, 0, 0, 100, 1'b0, 1'b0, "R5 ch3");
        chk(int'(out_code), 100, "R6 ch3 no flags");
        // R6: complete a block with no flags, offsets must hold.
        for (int i = 0; i < NCH * BLK - NCH; i++)
            step(0, 0, 0, 0, 1'b0, 1'b0, "R6 empty block");
        step(100, 0, 0, 0, 1'b0, 1'b0, "R6 ch0");
        chk(int'(out_code), 95, "R6 ch0 held");
        step(0, 100, 0, 0, 1'b0, 1'b0, "R6 ch1");
        chk(int'(out_code), 102, "R6 ch1 held");

        // R8: output extremes.
        do_reset();
        for (int r = 0; r < BLK; r++) begin
            step(511, 0, 0, 0, 1'b1, 1'b0, "R8 load ch0");
            step(0, -512, 0, 0, 1'b1, 1'b0, "R8 load ch1");
            step(0, 0, 0, 0, 1'b0, 1'b0, "R8 load ch2");
            step(0, 0, 0, 0, 1'b0, 1'b0, "R8 load ch3");
        end
        step(-512, 0, 0, 0, 1'b0, 1'b0, "R8 low");
        chk(int'(out_code), -1023, "R8 low extreme");
        step(0, 511, 0, 0, 1'b0, 1'b0, "R8 high");
        chk(int'(out_code), 1023, "R8 high extreme");

        // R3: sync mid-rotation restarts at channel 0.
        step(1, 2, 3, 4, 1'b0, 1'b1, "R3 sync sample");
        chk(int'(out_chan), 0, "R3 sync chan");
        step(1, 2, 3, 4, 1'b0, 1'b0, "R3 after sync");
        chk(int'(out_chan), 1, "R3 next chan");

        // R4 R5 R6 R7: pseudo-random codes, flags and sync against the model.
        lf = 32'h1ACE;
        for (int i = 0; i < 6000; i++) begin
            int a, b, cc, d;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
            a  = (lf & 1023) - 512;
            b  = ((lf >>> 10) & 63) - 32;
            cc = ((lf >>> 16) & 1023) - 512;
            d  = ((lf >>> 4) & 15) - 8;
            step(a, b, cc, d, ((lf >>> 26) & 3) != 0,
                 ((lf >>> 20) & 255) == 0, "R4 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule